// File: doc/BRIEF.md
# Opcode Addressing-Mode and Cycle Decoder

This block is a purely combinational decoder for the instruction set of a classic 8-bit accumulator processor. It looks at one opcode byte and reports several properties of that instruction:

- its addressing mode;
- its length in bytes;
- its base cycle count;
- the index register it uses;
- a class code;
- whether the byte is an undefined opcode.

A fetch unit uses the length to find the next opcode. A sequencer uses the mode, index and class to plan operand access and execution.

The opcode space is split on bits [1:0] into three regular groups, and each group has its own table indexed by bits [4:2]. The group with bits [1:0] = 00 also holds the one-off opcodes: branches, jumps, call, returns, break, stack operations, register steps, transfers and flag operations. The extra cycle an indexed access may need when it crosses a page is reported on a flag and is not added to the base count. The cycle count of a taken branch comes out on its own port.

Top module: `insn_mode_decoder`

## Requirements

Encodings used on the ports:

| Output | Code | Meaning |
|---|---|---|
| mode | 0 | implied |
| mode | 1 | accumulator |
| mode | 2 | immediate |
| mode | 3 | zero page |
| mode | 4 | zero page + X |
| mode | 5 | zero page + Y |
| mode | 6 | absolute |
| mode | 7 | absolute + X |
| mode | 8 | absolute + Y |
| mode | 9 | (zp + X) indirect |
| mode | 10 | (zp) indirect + Y |
| mode | 11 | relative |
| mode | 12 | indirect absolute |
| index | 0 | none |
| index | 1 | X |
| index | 2 | Y |
| class | 0 | illegal |
| class | 1 | alu/compare |
| class | 2 | load |
| class | 3 | store |
| class | 4 | read-modify-write |
| class | 5 | branch |
| class | 6 | jump |
| class | 7 | call |
| class | 8 | return |
| class | 9 | push |
| class | 10 | pull |
| class | 11 | transfer |
| class | 12 | flag op |
| class | 13 | register step |
| class | 14 | no-op |
| class | 15 | break |

- R1: Opcodes with bits[1:0]=01 decode from bits[4:0] as follows. 0x01 gives mode 9 with 6 cycles. 0x05 gives mode 3 with 3 cycles. 0x09 gives mode 2 with 2 cycles. 0x0D gives mode 6 with 4 cycles. 0x11 gives mode 10 with 5 cycles. 0x15 gives mode 4 with 4 cycles. 0x19 gives mode 8 with 4 cycles. 0x1D gives mode 7 with 4 cycles. Opcode 0x89 is illegal and every other opcode of this group is legal.
- R2: Opcodes with bits[1:0]=10 decode from bits[4:0] as follows. 0x02 gives immediate with 2 cycles and is legal only as 0xA2. 0x06 gives zero page with 5 cycles. 0x0A gives accumulator with 2 cycles, for bits[7:5] below 4. 0x0E gives absolute with 6 cycles. 0x16 gives zero page indexed with 6 cycles. 0x1E gives absolute indexed with 7 cycles and is illegal as 0x9E.
- R3: In that group, opcodes with bits[7:5] = 100 or 101 (the X-register store and load) use Y for their indexed modes: mode 5 or mode 8, index 2. All other indexed opcodes of the group use X.
- R4: Opcodes with bits[1:0]=00 are the compare, bit-test, Y-load and Y-store forms. Each is 0xA0, 0xC0 or 0xE0 for immediate with 2 cycles, 0x24, 0x84, 0xA4, 0xC4 or 0xE4 for zero page with 3 cycles, 0x2C, 0x8C, 0xAC, 0xCC or 0xEC for absolute with 4 cycles, 0x94 or 0xB4 for zero page + X with 4 cycles, or 0xBC for absolute + X with 4 cycles.
- R5: The length is 1 for modes 0 and 1. It is 2 for modes 2, 3, 4, 5, 9, 10 and 11. It is 3 for modes 6, 7, 8 and 12.
- R6: The index is 1 for modes 4, 7 and 9, 2 for modes 5, 8 and 10, and 0 otherwise.
- R7: The page-cross flag is 1 exactly for modes 7, 8 and 10.
- R8: Every byte with bits[1:0]=11 is illegal, and so is every byte that the other requirements leave undefined. An illegal byte gives illegal=1, length 1, mode 0, cycles 0, class 0, index 0, page-cross 0 and taken cycles 0.
- R9: The one-off opcodes have these mode, cycles and class:
  - 0x00 break: mode 0, 7 cycles, length 1.
  - 0x20 call: mode 6, 6 cycles.
  - 0x4C jump: mode 6, 3 cycles.
  - 0x6C jump: mode 12, 5 cycles.
  - 0x40 and 0x60 return: 6 cycles.
  - 0x08 and 0x48 push: 3 cycles.
  - 0x28 and 0x68 pull: 4 cycles.
  - 0x8A, 0xAA, 0x98, 0xA8, 0x9A and 0xBA transfer: 2 cycles.
  - 0x18, 0x38, 0x58, 0x78, 0xB8, 0xD8 and 0xF8 flag op: 2 cycles.
  - 0x88, 0xC8, 0xCA and 0xE8 register step: 2 cycles.
  - 0xEA no-op: 2 cycles.

  All of these except 0x20, 0x4C and 0x6C use mode 0.
- R10: Opcodes with bits[4:0]=0x10 are branches: mode 11, 2 cycles, taken cycles 3. Every other opcode reports taken cycles 0.
- R11: The class is 3 for opcodes with bits[1:0]=01 and bits[7:5]=100, and 2 when bits[7:5]=101. For the shift, rotate, increment and decrement memory forms of the bits[1:0]=10 group it is 4. The X-register, Y-register and accumulator loads give 2 and the matching stores give 3. The remaining memory forms of R1 and R4 give 1.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Opcode byte to decode |
| mode_o | output | 4 | Addressing-mode code |
| length_o | output | 2 | Instruction length in bytes |
| cycles_o | output | 4 | Base cycle count |
| taken_cycles_o | output | 4 | Cycle count of a taken branch, else 0 |
| index_o | output | 2 | Index register code |
| class_o | output | 4 | Instruction class code |
| illegal_o | output | 1 | Undefined opcode |
| page_cross_o | output | 1 | One extra cycle is possible on a page crossing |

## Verification

The assertions assume that the opcode input is a known value that has settled before the outputs are examined. They are guarded so that they evaluate nothing while the byte holds unknown bits. The bench drives only fully defined bytes. It changes them one full clock period before sampling, so every check sees settled outputs. The sweep covers all 256 byte values, so each table row, each Y substitution and each undefined byte is seen.

// File: rtl/imd_pkg.sv
package imd_pkg;

    localparam int CYC_W      = 4;
    localparam int LEN_W      = 2;
    localparam int TAKEN_CYC  = 3;

    typedef enum logic [3:0] {
        MODE_IMP = 4'd0,
        MODE_ACC = 4'd1,
        MODE_IMM = 4'd2,
        MODE_ZP  = 4'd3,
        MODE_ZPX = 4'd4,
        MODE_ZPY = 4'd5,
        MODE_ABS = 4'd6,
        MODE_ABX = 4'd7,
        MODE_ABY = 4'd8,
        MODE_IZX = 4'd9,
        MODE_IZY = 4'd10,
        MODE_REL = 4'd11,
        MODE_IND = 4'd12
    } mode_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_X    = 2'd1,
        IDX_Y    = 2'd2
    } idx_e;

    typedef enum logic [3:0] {
        CLS_ILLEGAL  = 4'd0,
        CLS_ALU      = 4'd1,
        CLS_LOAD     = 4'd2,
        CLS_STORE    = 4'd3,
        CLS_RMW      = 4'd4,
        CLS_BRANCH   = 4'd5,
        CLS_JUMP     = 4'd6,
        CLS_CALL     = 4'd7,
        CLS_RETURN   = 4'd8,
        CLS_PUSH     = 4'd9,
        CLS_PULL     = 4'd10,
        CLS_TRANSFER = 4'd11,
        CLS_FLAG     = 4'd12,
        CLS_STEP     = 4'd13,
        CLS_NOP      = 4'd14,
        CLS_BREAK    = 4'd15
    } cls_e;

    typedef struct packed {
        logic             legal;
        mode_e            mode;
        logic [CYC_W-1:0] cycles;
        cls_e             cls;
    } grp_dec_t;

    localparam grp_dec_t DEC_ILLEGAL = '{
        legal:  1'b0,
        mode:   MODE_IMP,
        cycles: '0,
        cls:    CLS_ILLEGAL
    };

    function automatic grp_dec_t mk_dec(mode_e m, int unsigned c, cls_e k);
        grp_dec_t d;
        d.legal  = 1'b1;
        d.mode   = m;
        d.cycles = CYC_W'(c);
        d.cls    = k;
        return d;
    endfunction

endpackage

// File: rtl/imd_alu_grp.sv
// Table for opcodes with bits[1:0] = 01 (accumulator arithmetic, load, store).
module imd_alu_grp
    import imd_pkg::*;
(
    input  logic [2:0] aaa_i,
    input  logic [2:0] bbb_i,
    output grp_dec_t   dec_o
);

    localparam logic [2:0] OP_STORE = 3'd4;
    localparam logic [2:0] OP_LOAD  = 3'd5;
    localparam logic [2:0] B_IMM    = 3'd2;

    cls_e mem_cls;

    always_comb begin
        unique case (aaa_i)
            OP_STORE: mem_cls = CLS_STORE;
            OP_LOAD:  mem_cls = CLS_LOAD;
            default:  mem_cls = CLS_ALU;
        endcase
    end

    always_comb begin
        dec_o = DEC_ILLEGAL;
        unique case (bbb_i)
            3'd0: dec_o = mk_dec(MODE_IZX, 6, mem_cls);
            3'd1: dec_o = mk_dec(MODE_ZP,  3, mem_cls);
            3'd2: dec_o = mk_dec(MODE_IMM, 2, mem_cls);
            3'd3: dec_o = mk_dec(MODE_ABS, 4, mem_cls);
            3'd4: dec_o = mk_dec(MODE_IZY, 5, mem_cls);
            3'd5: dec_o = mk_dec(MODE_ZPX, 4, mem_cls);
            3'd6: dec_o = mk_dec(MODE_ABY, 4, mem_cls);
            3'd7: dec_o = mk_dec(MODE_ABX, 4, mem_cls);
        endcase
        // storing to an immediate operand is undefined
        if (aaa_i == OP_STORE && bbb_i == B_IMM) begin
            dec_o = DEC_ILLEGAL;
        end
    end

endmodule

// File: rtl/imd_rmw_grp.sv
// Table for opcodes with bits[1:0] = 10 (shifts, inc/dec, X load/store,
// plus the implied transfers, X step and no-op that share the group).
module imd_rmw_grp
    import imd_pkg::*;
(
    input  logic [2:0] aaa_i,
    input  logic [2:0] bbb_i,
    output grp_dec_t   dec_o
);

    localparam logic [2:0] OP_STX = 3'd4;
    localparam logic [2:0] OP_LDX = 3'd5;
    localparam logic [2:0] OP_DEC = 3'd6;

    logic xreg;
    cls_e mem_cls;

    assign xreg = (aaa_i == OP_STX) || (aaa_i == OP_LDX);

    always_comb begin
        unique case (aaa_i)
            OP_STX:  mem_cls = CLS_STORE;
            OP_LDX:  mem_cls = CLS_LOAD;
            default: mem_cls = CLS_RMW;
        endcase
    end

    always_comb begin
        dec_o = DEC_ILLEGAL;
        unique case (bbb_i)
            3'd0: begin
                if (aaa_i == OP_LDX) dec_o = mk_dec(MODE_IMM, 2, CLS_LOAD);
            end
            3'd1: dec_o = mk_dec(MODE_ZP, 5, mem_cls);
            3'd2: begin
                unique case (aaa_i)
                    OP_STX:  dec_o = mk_dec(MODE_IMP, 2, CLS_TRANSFER);
                    OP_LDX:  dec_o = mk_dec(MODE_IMP, 2, CLS_TRANSFER);
                    OP_DEC:  dec_o = mk_dec(MODE_IMP, 2, CLS_STEP);
                    3'd7:    dec_o = mk_dec(MODE_IMP, 2, CLS_NOP);
                    default: dec_o = mk_dec(MODE_ACC, 2, CLS_RMW);
                endcase
            end
            3'd3: dec_o = mk_dec(MODE_ABS, 6, mem_cls);
            3'd4: dec_o = DEC_ILLEGAL;
            3'd5: dec_o = mk_dec(xreg ? MODE_ZPY : MODE_ZPX, 6, mem_cls);
            3'd6: begin
                if (xreg) dec_o = mk_dec(MODE_IMP, 2, CLS_TRANSFER);
            end
            3'd7: begin
                if (aaa_i == OP_LDX)      dec_o = mk_dec(MODE_ABY, 7, CLS_LOAD);
                else if (aaa_i != OP_STX) dec_o = mk_dec(MODE_ABX, 7, CLS_RMW);
            end
        endcase
    end

endmodule

// File: rtl/imd_ctl_grp.sv
// Table for opcodes with bits[1:0] = 00: Y-register and compare memory forms
// and the one-off control, stack, step, transfer and flag opcodes.
module imd_ctl_grp
    import imd_pkg::*;
(
    input  logic [2:0] aaa_i,
    input  logic [2:0] bbb_i,
    output grp_dec_t   dec_o
);

    localparam logic [2:0] OP_STY = 3'd4;
    localparam logic [2:0] OP_LDY = 3'd5;

    cls_e mem_cls;

    always_comb begin
        unique case (aaa_i)
            OP_STY:  mem_cls = CLS_STORE;
            OP_LDY:  mem_cls = CLS_LOAD;
            default: mem_cls = CLS_ALU;
        endcase
    end

    always_comb begin
        dec_o = DEC_ILLEGAL;
        unique case (bbb_i)
            3'd0: begin
                unique case (aaa_i)
                    3'd0:    dec_o = mk_dec(MODE_IMP, 7, CLS_BREAK);
                    3'd1:    dec_o = mk_dec(MODE_ABS, 6, CLS_CALL);
                    3'd2:    dec_o = mk_dec(MODE_IMP, 6, CLS_RETURN);
                    3'd3:    dec_o = mk_dec(MODE_IMP, 6, CLS_RETURN);
                    3'd4:    dec_o = DEC_ILLEGAL;
                    default: dec_o = mk_dec(MODE_IMM, 2, mem_cls);
                endcase
            end
            3'd1: begin
                if (aaa_i == 3'd1 || aaa_i >= OP_STY)
                    dec_o = mk_dec(MODE_ZP, 3, mem_cls);
            end
            3'd2: begin
                unique case (aaa_i)
                    3'd0:    dec_o = mk_dec(MODE_IMP, 3, CLS_PUSH);
                    3'd1:    dec_o = mk_dec(MODE_IMP, 4, CLS_PULL);
                    3'd2:    dec_o = mk_dec(MODE_IMP, 3, CLS_PUSH);
                    3'd3:    dec_o = mk_dec(MODE_IMP, 4, CLS_PULL);
                    OP_LDY:  dec_o = mk_dec(MODE_IMP, 2, CLS_TRANSFER);
                    default: dec_o = mk_dec(MODE_IMP, 2, CLS_STEP);
                endcase
            end
            3'd3: begin
                unique case (aaa_i)
                    3'd0:    dec_o = DEC_ILLEGAL;
                    3'd2:    dec_o = mk_dec(MODE_ABS, 3, CLS_JUMP);
                    3'd3:    dec_o = mk_dec(MODE_IND, 5, CLS_JUMP);
                    default: dec_o = mk_dec(MODE_ABS, 4, mem_cls);
                endcase
            end
            3'd4: dec_o = mk_dec(MODE_REL, 2, CLS_BRANCH);
            3'd5: begin
                if (aaa_i == OP_STY || aaa_i == OP_LDY)
                    dec_o = mk_dec(MODE_ZPX, 4, mem_cls);
            end
            3'd6: begin
                if (aaa_i == OP_STY) dec_o = mk_dec(MODE_IMP, 2, CLS_TRANSFER);
                else                 dec_o = mk_dec(MODE_IMP, 2, CLS_FLAG);
            end
            3'd7: begin
                if (aaa_i == OP_LDY) dec_o = mk_dec(MODE_ABX, 4, CLS_LOAD);
            end
        endcase
    end

endmodule

// File: rtl/imd_mode_attr.sv
// Per-mode attributes: byte length, index register, page-cross possibility.
module imd_mode_attr
    import imd_pkg::*;
(
    input  mode_e            mode_i,
    output logic [LEN_W-1:0] length_o,
    output idx_e             index_o,
    output logic             page_cross_o
);

    always_comb begin
        length_o     = LEN_W'(1);
        index_o      = IDX_NONE;
        page_cross_o = 1'b0;
        case (mode_i)
            MODE_IMP, MODE_ACC: length_o = LEN_W'(1);
            MODE_IMM, MODE_ZP, MODE_REL: length_o = LEN_W'(2);
            MODE_ZPX, MODE_IZX: begin
                length_o = LEN_W'(2);
                index_o  = IDX_X;
            end
            MODE_ZPY: begin
                length_o = LEN_W'(2);
                index_o  = IDX_Y;
            end
            MODE_IZY: begin
                length_o     = LEN_W'(2);
                index_o      = IDX_Y;
                page_cross_o = 1'b1;
            end
            MODE_ABS, MODE_IND: length_o = LEN_W'(3);
            MODE_ABX: begin
                length_o     = LEN_W'(3);
                index_o      = IDX_X;
                page_cross_o = 1'b1;
            end
            MODE_ABY: begin
                length_o     = LEN_W'(3);
                index_o      = IDX_Y;
                page_cross_o = 1'b1;
            end
            default: length_o = LEN_W'(1);
        endcase
    end

endmodule

// File: rtl/insn_mode_decoder.sv
module insn_mode_decoder
    import imd_pkg::*;
(
    input  logic [7:0] opcode_i,
    output logic [3:0] mode_o,
    output logic [1:0] length_o,
    output logic [3:0] cycles_o,
    output logic [3:0] taken_cycles_o,
    output logic [1:0] index_o,
    output logic [3:0] class_o,
    output logic       illegal_o,
    output logic       page_cross_o
);

    grp_dec_t dec_ctl;
    grp_dec_t dec_alu;
    grp_dec_t dec_rmw;
    grp_dec_t dec_sel;

    logic [LEN_W-1:0] len_w;
    idx_e             idx_w;
    logic             pgx_w;

    imd_ctl_grp u_ctl (.aaa_i(opcode_i[7:5]), .bbb_i(opcode_i[4:2]), .dec_o(dec_ctl));
    imd_alu_grp u_alu (.aaa_i(opcode_i[7:5]), .bbb_i(opcode_i[4:2]), .dec_o(dec_alu));
    imd_rmw_grp u_rmw (.aaa_i(opcode_i[7:5]), .bbb_i(opcode_i[4:2]), .dec_o(dec_rmw));

    always_comb begin
        unique case (opcode_i[1:0])
            2'b00: dec_sel = dec_ctl;
            2'b01: dec_sel = dec_alu;
            2'b10: dec_sel = dec_rmw;
            2'b11: dec_sel = DEC_ILLEGAL;
        endcase
    end

    imd_mode_attr u_attr (
        .mode_i       (dec_sel.mode),
        .length_o     (len_w),
        .index_o      (idx_w),
        .page_cross_o (pgx_w)
    );

    assign mode_o         = dec_sel.mode;
    assign length_o       = len_w;
    assign cycles_o       = dec_sel.cycles;
    assign taken_cycles_o = (dec_sel.cls == CLS_BRANCH) ? 4'(TAKEN_CYC) : 4'd0;
    assign index_o        = idx_w;
    assign class_o        = dec_sel.cls;
    assign illegal_o      = ~dec_sel.legal;
    assign page_cross_o   = pgx_w;

endmodule

// File: rtl/imd_checker.sv
module imd_checker (
    input logic [7:0] opcode_i,
    input logic [3:0] mode_o,
    input logic [1:0] length_o,
    input logic [3:0] cycles_o,
    input logic [3:0] taken_cycles_o,
    input logic [1:0] index_o,
    input logic [3:0] class_o,
    input logic       illegal_o,
    input logic       page_cross_o
);

    always_comb begin
        if (!$isunknown(opcode_i)) begin
            // R1: group 01 is fully legal apart from 0x89
            assert_alu_group_legal_R1: assert (!(opcode_i[1:0] == 2'b01 && opcode_i != 8'h89) || !illegal_o)
                else $error("alu group opcode %02h flagged illegal", opcode_i);
            // R3: X-register load/store indexed forms index through Y
            assert_xreg_uses_y_R3: assert (!(opcode_i[1:0] == 2'b10 && opcode_i[7:6] == 2'b10
                                             && opcode_i[4] && !illegal_o && class_o != 4'd11)
                                           || index_o == 2'd2)
                else $error("opcode %02h index %0d", opcode_i, index_o);
            // R7: a page-cross flag only appears on an indexed multi-byte form
            assert_page_needs_index_R7: assert (!page_cross_o || (index_o != 2'd0 && length_o >= 2'd2))
                else $error("opcode %02h page flag without index", opcode_i);
            // R8: bits[1:0]=11 is always undefined
            assert_col3_illegal_R8: assert (opcode_i[1:0] != 2'b11 || illegal_o)
                else $error("opcode %02h not illegal", opcode_i);
            // R8: undefined opcodes report the single-byte null decode
            assert_illegal_shape_R8: assert (!illegal_o || (length_o == 2'd1 && cycles_o == 4'd0
                                              && class_o == 4'd0 && index_o == 2'd0 && !page_cross_o))
                else $error("opcode %02h illegal shape wrong", opcode_i);
            // R10: branch column gives relative mode and taken count 3
            assert_branch_taken_R10: assert (opcode_i[4:0] != 5'h10 || (mode_o == 4'd11 && taken_cycles_o == 4'd3
                                              && cycles_o == 4'd2))
                else $error("opcode %02h branch decode wrong", opcode_i);
            // R10: nothing but a branch reports taken cycles
            assert_taken_only_branch_R10: assert (opcode_i[4:0] == 5'h10 || taken_cycles_o == 4'd0)
                else $error("opcode %02h stray taken cycles", opcode_i);
            // R5: implied and accumulator forms are single byte
            assert_one_byte_R5: assert (!(mode_o <= 4'd1) || length_o == 2'd1)
                else $error("opcode %02h length %0d", opcode_i, length_o);
        end
    end

endmodule

bind insn_mode_decoder imd_checker u_imd_checker (
    .opcode_i       (opcode_i),
    .mode_o         (mode_o),
    .length_o       (length_o),
    .cycles_o       (cycles_o),
    .taken_cycles_o (taken_cycles_o),
    .index_o        (index_o),
    .class_o        (class_o),
    .illegal_o      (illegal_o),
    .page_cross_o   (page_cross_o)
);

// File: tb/insn_mode_decoder_test.sv
`timescale 1ns/1ps
module insn_mode_decoder_test;

    localparam int M_IMP = 0, M_ACC = 1, M_IMM = 2, M_ZP = 3, M_ZPX = 4, M_ZPY = 5,
                   M_ABS = 6, M_ABX = 7, M_ABY = 8, M_IZX = 9, M_IZY = 10, M_REL = 11, M_IND = 12;
    localparam int K_ILL = 0, K_ALU = 1, K_LD = 2, K_ST = 3, K_RMW = 4, K_BR = 5, K_JMP = 6,
                   K_CALL = 7, K_RET = 8, K_PUSH = 9, K_PULL = 10, K_XFER = 11, K_FLAG = 12,
                   K_STEP = 13, K_NOP = 14, K_BRK = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode;
    logic [3:0] mode_o, cycles_o, taken_o, class_o;
    logic [1:0] length_o, index_o;
    logic       illegal_o, page_o;

    int checks = 0;
    int failures = 0;
    int cyc_count = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    insn_mode_decoder uut (
        .opcode_i       (opcode),
        .mode_o         (mode_o),
        .length_o       (length_o),
        .cycles_o       (cycles_o),
        .taken_cycles_o (taken_o),
        .index_o        (index_o),
        .class_o        (class_o),
        .illegal_o      (illegal_o),
        .page_cross_o   (page_o)
    );

    typedef struct {
        int    mode;
        int    cyc;
        int    cls;
        string tag;
    } exp_t;

    function automatic exp_t expect_op(input logic [7:0] op);
        exp_t e;
        logic [4:0] lo5 = op[4:0];
        logic [2:0] hi3 = op[7:5];
        e.mode = M_IMP; e.cyc = 0; e.cls = K_ILL; e.tag = "R8";
        case (op)
            8'h00: begin e.cyc = 7; e.cls = K_BRK; e.tag = "R9"; end
            8'h20: begin e.mode = M_ABS; e.cyc = 6; e.cls = K_CALL; e.tag = "R9"; end
            8'h40, 8'h60: begin e.cyc = 6; e.cls = K_RET; e.tag = "R9"; end
            8'h4C: begin e.mode = M_ABS; e.cyc = 3; e.cls = K_JMP; e.tag = "R9"; end
            8'h6C: begin e.mode = M_IND; e.cyc = 5; e.cls = K_JMP; e.tag = "R9"; end
            8'h08, 8'h48: begin e.cyc = 3; e.cls = K_PUSH; e.tag = "R9"; end
            8'h28, 8'h68: begin e.cyc = 4; e.cls = K_PULL; e.tag = "R9"; end
            8'h8A, 8'hAA, 8'h98, 8'hA8, 8'h9A, 8'hBA: begin e.cyc = 2; e.cls = K_XFER; e.tag = "R9"; end
            8'h18, 8'h38, 8'h58, 8'h78, 8'hB8, 8'hD8, 8'hF8: begin e.cyc = 2; e.cls = K_FLAG; e.tag = "R9"; end
            8'h88, 8'hC8, 8'hCA, 8'hE8: begin e.cyc = 2; e.cls = K_STEP; e.tag = "R9"; end
            8'hEA: begin e.cyc = 2; e.cls = K_NOP; e.tag = "R9"; end
            default: begin
                if (lo5 == 5'h10) begin
                    e.mode = M_REL; e.cyc = 2; e.cls = K_BR; e.tag = "R10";
                end else if (op[1:0] == 2'b01 && op != 8'h89) begin
                    e.tag = "R1";
                    e.cls = (hi3 == 3'd4) ? K_ST : (hi3 == 3'd5) ? K_LD : K_ALU;
                    case (lo5)
                        5'h01: begin e.mode = M_IZX; e.cyc = 6; end
                        5'h05: begin e.mode = M_ZP;  e.cyc = 3; end
                        5'h09: begin e.mode = M_IMM; e.cyc = 2; end
                        5'h0D: begin e.mode = M_ABS; e.cyc = 4; end
                        5'h11: begin e.mode = M_IZY; e.cyc = 5; end
                        5'h15: begin e.mode = M_ZPX; e.cyc = 4; end
                        5'h19: begin e.mode = M_ABY; e.cyc = 4; end
                        default: begin e.mode = M_ABX; e.cyc = 4; end
                    endcase
                end else if (op[1:0] == 2'b10) begin
                    bit xr = (hi3 == 3'd4 || hi3 == 3'd5);
                    bit ok = 1'b0;
                    int m = M_IMP, c = 0;
                    case (lo5)
                        5'h02: begin ok = (op == 8'hA2); m = M_IMM; c = 2; end
                        5'h06: begin ok = 1'b1; m = M_ZP; c = 5; end
                        5'h0A: begin ok = (hi3 < 3'd4); m = M_ACC; c = 2; end
                        5'h0E: begin ok = 1'b1; m = M_ABS; c = 6; end
                        5'h16: begin ok = 1'b1; m = xr ? M_ZPY : M_ZPX; c = 6; end
                        5'h1E: begin ok = (op != 8'h9E); m = xr ? M_ABY : M_ABX; c = 7; end
                        default: ok = 1'b0;
                    endcase
                    if (ok) begin
                        e.mode = m; e.cyc = c;
                        e.cls = (hi3 == 3'd4) ? K_ST : (hi3 == 3'd5) ? K_LD : K_RMW;
                        e.tag = (xr && (m == M_ZPY || m == M_ABY)) ? "R3" : "R2";
                    end
                end else if (op[1:0] == 2'b00) begin
                    bit ok = 1'b1;
                    case (op)
                        8'hA0, 8'hC0, 8'hE0: begin e.mode = M_IMM; e.cyc = 2; end
                        8'h24, 8'h84, 8'hA4, 8'hC4, 8'hE4: begin e.mode = M_ZP; e.cyc = 3; end
                        8'h2C, 8'h8C, 8'hAC, 8'hCC, 8'hEC: begin e.mode = M_ABS; e.cyc = 4; end
                        8'h94, 8'hB4: begin e.mode = M_ZPX; e.cyc = 4; end
                        8'hBC: begin e.mode = M_ABX; e.cyc = 4; end
                        default: ok = 1'b0;
                    endcase
                    if (ok) begin
                        e.cls = (hi3 == 3'd4) ? K_ST : (hi3 == 3'd5) ? K_LD : K_ALU;
                        e.tag = "R4";
                    end
                end
            end
        endcase
        return e;
    endfunction

    function automatic int len_of(input int m);
        if (m == M_IMP || m == M_ACC) return 1;
        if (m == M_ABS || m == M_ABX || m == M_ABY || m == M_IND) return 3;
        return 2;
    endfunction

    function automatic int idx_of(input int m);
        if (m == M_ZPX || m == M_ABX || m == M_IZX) return 1;
        if (m == M_ZPY || m == M_ABY || m == M_IZY) return 2;
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp, input logic [7:0] op);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s op=%02h actual=%0d expected=%0d", tag, what, op, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] op);
        @(negedge clk);
        opcode = op;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_count <= cyc_count + 1;
        if (cyc_count > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        opcode = 8'hEA;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // full sweep of the opcode space
        for (int i = 0; i < 256; i++) begin
            exp_t e;
            logic [7:0] op = 8'(i);
            e = expect_op(op);
            apply(op);
            check(e.tag, "mode",    int'(mode_o),    e.mode, op);
            check(e.tag, "cycles",  int'(cycles_o),  e.cyc,  op);
            check("R11", "class",   int'(class_o),   e.cls,  op);
            check("R8",  "illegal", int'(illegal_o), (e.cls == K_ILL) ? 1 : 0, op);
            check("R5",  "length",  int'(length_o),  len_of(e.mode), op);
            check("R6",  "index",   int'(index_o),   idx_of(e.mode), op);
            check("R7",  "page",    int'(page_o),
                  (e.mode == M_ABX || e.mode == M_ABY || e.mode == M_IZY) ? 1 : 0, op);
            check("R10", "taken",   int'(taken_o),   (e.cls == K_BR) ? 3 : 0, op);
        end

        // fixed corner cases with literal expectations
        apply(8'h00); check("R9", "break length", int'(length_o), 1, 8'h00);
                      check("R9", "break cycles", int'(cycles_o), 7, 8'h00);
        apply(8'hB6); check("R3", "ldx zp,Y index", int'(index_o), 2, 8'hB6);
                      check("R3", "ldx zp,Y mode",  int'(mode_o),  5, 8'hB6);
        apply(8'hBE); check("R3", "ldx abs,Y page", int'(page_o), 1, 8'hBE);
        apply(8'h9E); check("R8", "9E illegal", int'(illegal_o), 1, 8'h9E);
                      check("R8", "9E length",  int'(length_o),  1, 8'h9E);
        apply(8'h89); check("R1", "89 illegal", int'(illegal_o), 1, 8'h89);
        apply(8'hF0); check("R10", "beq taken", int'(taken_o), 3, 8'hF0);
        apply(8'h71); check("R7", "izy page", int'(page_o), 1, 8'h71);
        apply(8'h1E); check("R2", "asl abs,X cycles", int'(cycles_o), 7, 8'h1E);
        apply(8'h6C); check("R9", "jmp ind length", int'(length_o), 3, 8'h6C);
        apply(8'hFF); check("R8", "FF class", int'(class_o), 0, 8'hFF);
        apply(8'hAC); check("R4", "ldy abs cycles", int'(cycles_o), 4, 8'hAC);

        done = 1'b1;
        finish_run();
    end

endmodule